// File: doc/BRIEF.md
# Transfer Data Sniffer Checksum Unit

The sniffer watches the read-data beats of a multi-channel transfer engine and folds the beats of one chosen channel into a 32-bit accumulator. A configuration write sets the enable bit, the 4-bit channel to watch, the calculation mode, an input byte-reverse flag and two readback transforms (bit reverse and complement). Software loads a seed into the accumulator before the transfer, lets the engine run, and then reads the result.

Byte reversal is applied to each beat before it enters the calculation. The channel's own read-path swap happens upstream, so turning on both swaps leaves the sniffed data in its original order. The readback transforms only change how the stored value appears on `acc_rdata`. The stored state never changes because of them, so a transform can be turned on or off between reads without disturbing an accumulation in progress.

Top module: `sniff_unit`

## Requirements
- R1: After reset the accumulator is zero, the unit is disabled and `acc_rdata` reads 0.
- R2: While the enable bit is clear, observed beats leave the accumulator unchanged.
- R3: While enabled, only beats whose `obs_chan` equals the configured channel update the accumulator, once per beat. Beats on other channels have no effect.
- R4: `seed_we` loads `seed_data` into the accumulator at the next edge. If a matching beat arrives in the same cycle, the seed wins and the beat is dropped.
- R5: Mode code 0 is CRC-32 with polynomial 0x04C11DB7. It shifts left, takes data bit 31 first, and has no pre- or post-inversion.
- R6: Mode code 1 is the reflected CRC-32. It shifts right with polynomial 0xEDB88320 and takes data bit 0 first.
- R7: Mode code 2 is CRC-16 with polynomial 0x1021. It runs MSB-first over all 32 data bits on accumulator bits 15:0, and bits 31:16 become zero on each update.
- R8: Mode code 3 XORs each beat into the accumulator.
- R9: Mode code 4 adds each beat to the accumulator modulo 2^32.
- R10: With byte reverse set, the bytes of a beat are reordered (bits 7:0 become 31:24, and so on) before the calculation.
- R11: With output reverse set, `acc_rdata` shows the accumulator bit-reversed (bit 0 at bit 31). The stored value is unaffected.
- R12: With output invert set, `acc_rdata` shows the bitwise complement of the accumulator. The stored value is unaffected. When both transforms are set, both apply.
- R13: Mode codes 5 to 7 are unused, and matching beats leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_en | input | 1 | Enable bit |
| cfg_chan | input | 4 | Channel to observe |
| cfg_mode | input | 3 | Calculation mode code |
| cfg_bswap | input | 1 | Byte reverse of incoming beats |
| cfg_orev | input | 1 | Bit-reverse result on readback |
| cfg_oinv | input | 1 | Complement result on readback |
| seed_we | input | 1 | Write seed into accumulator |
| seed_data | input | 32 | Seed value |
| obs_valid | input | 1 | Observed read beat present |
| obs_chan | input | 4 | Channel of the observed beat |
| obs_data | input | 32 | Data of the observed beat |
| acc_rdata | output | 32 | Accumulator as seen after readback transforms |

## Verification
The seed write and a matching observed beat can land on the same edge. The bench provokes this by raising `seed_we` and a beat on the selected channel in one cycle, with a nonzero prior accumulator in sum mode. It then requires the readback to equal the seed exactly, with no trace of the beat. One cycle later it sends a further beat to show that accumulation resumes from the seed.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    localparam int ACC_W  = 32;
    localparam int CHAN_W = 4;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_CRC32     = 3'd0,
        MODE_CRC32_REF = 3'd1,
        MODE_CRC16     = 3'd2,
        MODE_XOR       = 3'd3,
        MODE_SUM       = 3'd4
    } sniff_mode_e;

    typedef struct packed {
        logic              en;
        logic [CHAN_W-1:0] chan;
        logic [MODE_W-1:0] mode;
        logic              bswap;
        logic              orev;
        logic              oinv;
    } sniff_cfg_t;

    typedef struct packed {
        sniff_cfg_t       cfg;
        logic [ACC_W-1:0] acc;
    } sniff_state_t;

endpackage

// File: rtl/sniff_byterev.sv
module sniff_byterev #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    logic [W-1:0] swapped;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign swapped[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

    assign dout = en ? swapped : din;
endmodule

// File: rtl/sniff_crc_step.sv
module sniff_crc_step #(
    parameter int          DW      = 32,
    parameter int          CW      = 32,
    parameter logic [CW-1:0] POLY  = '0,
    parameter bit          REFLECT = 1'b0
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] crc_out
);
    if (REFLECT) begin : g_lsb_first
        always_comb begin
            logic [CW-1:0] c;
            logic          fb;
            c = crc_in;
            for (int i = 0; i < DW; i++) begin
                fb = c[0] ^ data[i];
                c  = c >> 1;
                if (fb) c = c ^ POLY;
            end
            crc_out = c;
        end
    end else begin : g_msb_first
        always_comb begin
            logic [CW-1:0] c;
            logic          fb;
            c = crc_in;
            for (int i = DW - 1; i >= 0; i--) begin
                fb = c[CW-1] ^ data[i];
                c  = c << 1;
                if (fb) c = c ^ POLY;
            end
            crc_out = c;
        end
    end
endmodule

// File: rtl/sniff_readout.sv
module sniff_readout #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc,
    input  logic         rev,
    input  logic         inv,
    output logic [W-1:0] dout
);
    logic [W-1:0] flipped;
    logic [W-1:0] ordered;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign flipped[i] = acc[W-1-i];
    end

    assign ordered = rev ? flipped : acc;
    assign dout    = inv ? ~ordered : ordered;
endmodule

// File: rtl/sniff_unit.sv
module sniff_unit
    import sniff_pkg::*;
#(
    parameter int          DATA_W   = ACC_W,
    parameter int          CRC16_W  = 16,
    parameter logic [31:0] POLY32   = 32'h04C11DB7,
    parameter logic [31:0] POLY32R  = 32'hEDB88320,
    parameter logic [15:0] POLY16   = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_en,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_bswap,
    input  logic              cfg_orev,
    input  logic              cfg_oinv,
    input  logic              seed_we,
    input  logic [DATA_W-1:0] seed_data,
    input  logic              obs_valid,
    input  logic [CHAN_W-1:0] obs_chan,
    input  logic [DATA_W-1:0] obs_data,
    output logic [DATA_W-1:0] acc_rdata
);
    localparam int HI_W = DATA_W - CRC16_W;

    sniff_state_t state_q;
    sniff_state_t state_d;

    logic              hit;
    logic [DATA_W-1:0] beat;
    logic [DATA_W-1:0] crc32_nxt;
    logic [DATA_W-1:0] crc32r_nxt;
    logic [CRC16_W-1:0] crc16_nxt;

    assign hit = state_q.cfg.en && obs_valid && (obs_chan == state_q.cfg.chan);

    sniff_byterev #(.W(DATA_W)) u_swap (
        .en  (state_q.cfg.bswap),
        .din (obs_data),
        .dout(beat)
    );

    sniff_crc_step #(.DW(DATA_W), .CW(DATA_W), .POLY(POLY32), .REFLECT(1'b0)) u_crc32 (
        .crc_in (state_q.acc),
        .data   (beat),
        .crc_out(crc32_nxt)
    );

    sniff_crc_step #(.DW(DATA_W), .CW(DATA_W), .POLY(POLY32R), .REFLECT(1'b1)) u_crc32r (
        .crc_in (state_q.acc),
        .data   (beat),
        .crc_out(crc32r_nxt)
    );

    sniff_crc_step #(.DW(DATA_W), .CW(CRC16_W), .POLY(POLY16), .REFLECT(1'b0)) u_crc16 (
        .crc_in (state_q.acc[CRC16_W-1:0]),
        .data   (beat),
        .crc_out(crc16_nxt)
    );

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d.cfg.en    = cfg_en;
            state_d.cfg.chan  = cfg_chan;
            state_d.cfg.mode  = cfg_mode;
            state_d.cfg.bswap = cfg_bswap;
            state_d.cfg.orev  = cfg_orev;
            state_d.cfg.oinv  = cfg_oinv;
        end
        if (seed_we) begin
            state_d.acc = seed_data;
        end else if (hit) begin
            case (sniff_mode_e'(state_q.cfg.mode))
                MODE_CRC32:     state_d.acc = crc32_nxt;
                MODE_CRC32_REF: state_d.acc = crc32r_nxt;
                MODE_CRC16:     state_d.acc = {{HI_W{1'b0}}, crc16_nxt};
                MODE_XOR:       state_d.acc = state_q.acc ^ beat;
                MODE_SUM:       state_d.acc = state_q.acc + beat;
                default:        state_d.acc = state_q.acc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    sniff_readout #(.W(DATA_W)) u_rd (
        .acc (state_q.acc),
        .rev (state_q.cfg.orev),
        .inv (state_q.cfg.oinv),
        .dout(acc_rdata)
    );
endmodule

// File: rtl/sniff_unit_chk.sv
module sniff_unit_chk
    import sniff_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              seed_we,
    input logic [ACC_W-1:0]  seed_data,
    input logic              obs_valid,
    input logic [CHAN_W-1:0] obs_chan,
    input sniff_state_t      st,
    input logic [ACC_W-1:0]  acc_rdata
);
    logic match;
    assign match = st.cfg.en && obs_valid && (obs_chan == st.cfg.chan);

    // R4
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_we |=> st.acc == $past(seed_data));

    // R2
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_we && !st.cfg.en) |=> $stable(st.acc));

    // R3
    other_chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_we && !match) |=> $stable(st.acc));

    // R7
    crc16_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_we && match && st.cfg.mode == 3'd2) |=> st.acc[31:16] == 16'h0);

    // R11
    plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.cfg.orev && !st.cfg.oinv) |-> acc_rdata == st.acc);

    // R12
    inv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.cfg.orev && st.cfg.oinv) |-> acc_rdata == ~st.acc);
endmodule

bind sniff_unit sniff_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_we  (seed_we),
    .seed_data(seed_data),
    .obs_valid(obs_valid),
    .obs_chan (obs_chan),
    .st       (state_q),
    .acc_rdata(acc_rdata)
);

// File: tb/tb_sniff_unit.sv
module tb_sniff_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_en = 1'b0, cfg_bswap = 1'b0, cfg_orev = 1'b0, cfg_oinv = 1'b0;
    logic [3:0]  cfg_chan = '0;
    logic [2:0]  cfg_mode = '0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_data = '0;
    logic        obs_valid = 1'b0;
    logic [3:0]  obs_chan = '0;
    logic [31:0] obs_data = '0;
    logic [31:0] acc_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sniff_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_chan(cfg_chan), .cfg_mode(cfg_mode),
        .cfg_bswap(cfg_bswap), .cfg_orev(cfg_orev), .cfg_oinv(cfg_oinv),
        .seed_we(seed_we), .seed_data(seed_data),
        .obs_valid(obs_valid), .obs_chan(obs_chan), .obs_data(obs_data),
        .acc_rdata(acc_rdata)
    );

    // Reference model, written from the requirements
    function automatic logic [31:0] bswap32(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [31:0] brev32(input logic [31:0] d);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = d[31-i];
        return r;
    endfunction

    function automatic logic [31:0] model(input logic [2:0] mode, input logic [31:0] acc,
                                          input logic [31:0] d);
        logic [31:0] c;
        logic [15:0] h;
        logic        fb;
        case (mode)
            3'd0: begin
                c = acc;
                for (int i = 31; i >= 0; i--) begin
                    fb = c[31] ^ d[i]; c = {c[30:0], 1'b0};
                    if (fb) c = c ^ 32'h04C11DB7;
                end
                return c;
            end
            3'd1: begin
                c = acc;
                for (int i = 0; i < 32; i++) begin
                    fb = c[0] ^ d[i]; c = {1'b0, c[31:1]};
                    if (fb) c = c ^ 32'hEDB88320;
                end
                return c;
            end
            3'd2: begin
                h = acc[15:0];
                for (int i = 31; i >= 0; i--) begin
                    fb = h[15] ^ d[i]; h = {h[14:0], 1'b0};
                    if (fb) h = h ^ 16'h1021;
                end
                return {16'h0, h};
            end
            3'd3: return acc ^ d;
            3'd4: return acc + d;
            default: return acc;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_tests++;
        if (acc_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: acc_rdata=%08h expected=%08h", req, acc_rdata, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic [3:0] ch, input logic [2:0] md,
                           input logic bs, input logic rv, input logic iv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_en = en; cfg_chan = ch; cfg_mode = md;
        cfg_bswap = bs; cfg_orev = rv; cfg_oinv = iv;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic seed(input logic [31:0] v);
        @(negedge clk);
        seed_we = 1'b1; seed_data = v;
        @(negedge clk);
        seed_we = 1'b0;
    endtask

    task automatic beat(input logic [3:0] ch, input logic [31:0] d);
        @(negedge clk);
        obs_valid = 1'b1; obs_chan = ch; obs_data = d;
        @(negedge clk);
        obs_valid = 1'b0;
    endtask

    // Stimulus table: mode, byte reverse, seed, beat0, beat1
    typedef struct packed {
        logic [2:0]  mode;
        logic        bs;
        logic [31:0] sd;
        logic [31:0] d0;
        logic [31:0] d1;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 32'hFFFFFFFF, 32'h12345678, 32'hCAFEBABE},  // R5
        '{3'd0, 1'b1, 32'h00000000, 32'hA5A5F00F, 32'h00000001},  // R5 R10
        '{3'd1, 1'b0, 32'hFFFFFFFF, 32'h87654321, 32'hDEADBEEF},  // R6
        '{3'd1, 1'b1, 32'h13579BDF, 32'h11223344, 32'h80000000},  // R6 R10
        '{3'd2, 1'b0, 32'hABCDFFFF, 32'h0000FFFF, 32'h31323334},  // R7
        '{3'd2, 1'b1, 32'h00001D0F, 32'hFEDCBA98, 32'h00000000},  // R7 R10
        '{3'd3, 1'b0, 32'h0F0F0F0F, 32'hFF00FF00, 32'h12345678},  // R8
        '{3'd3, 1'b1, 32'h00000000, 32'h01020304, 32'h00000000},  // R8 R10
        '{3'd4, 1'b0, 32'hFFFFFFF0, 32'h00000011, 32'h80000000},  // R9 wrap
        '{3'd4, 1'b1, 32'h00000001, 32'h000000FF, 32'hFFFFFFFF}   // R9 R10
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] e;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        check("R1 reset", 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'h0);

        // R2: disabled unit ignores beats on channel 0
        seed(32'h55AA55AA);
        beat(4'd0, 32'h11111111);
        check("R2 disabled", 32'h55AA55AA);

        for (int i = 0; i < NV; i++) begin
            set_cfg(1'b1, 4'd5, VECS[i].mode, VECS[i].bs, 1'b0, 1'b0);
            seed(VECS[i].sd);
            e = VECS[i].sd;
            beat(4'd5, VECS[i].d0);
            e = model(VECS[i].mode, e, VECS[i].bs ? bswap32(VECS[i].d0) : VECS[i].d0);
            beat(4'd5, VECS[i].d1);
            e = model(VECS[i].mode, e, VECS[i].bs ? bswap32(VECS[i].d1) : VECS[i].d1);
            check($sformatf("R5-9 table row %0d mode %0d", i, VECS[i].mode), e);
        end

        // R3: other channels ignored, selected channel counted
        set_cfg(1'b1, 4'd9, 3'd4, 1'b0, 1'b0, 1'b0);
        seed(32'd100);
        beat(4'd8, 32'd7);
        beat(4'd15, 32'd7);
        check("R3 other channels", 32'd100);
        beat(4'd9, 32'd7);
        check("R3 selected channel", 32'd107);

        // R4: seed collides with a matching beat
        @(negedge clk);
        seed_we = 1'b1; seed_data = 32'h0BADF00D;
        obs_valid = 1'b1; obs_chan = 4'd9; obs_data = 32'h00000100;
        @(negedge clk);
        seed_we = 1'b0; obs_valid = 1'b0;
        check("R4 seed over beat", 32'h0BADF00D);
        beat(4'd9, 32'h1);
        check("R4 resume after seed", 32'h0BADF00E);

        // R10: upstream swap plus local swap cancel
        set_cfg(1'b1, 4'd2, 3'd0, 1'b1, 1'b0, 1'b0);
        seed(32'hFFFFFFFF);
        d = 32'h89ABCDEF;
        beat(4'd2, bswap32(d));
        check("R10 swaps cancel", model(3'd0, 32'hFFFFFFFF, d));

        // R11/R12: readback transforms do not touch stored value
        set_cfg(1'b1, 4'd3, 3'd4, 1'b0, 1'b1, 1'b0);
        seed(32'h00000013);
        check("R11 bit reverse", 32'hC8000000);
        beat(4'd3, 32'h00000001);
        check("R11 reverse while adding", 32'h28000000);
        set_cfg(1'b1, 4'd3, 3'd4, 1'b0, 1'b0, 1'b1);
        check("R12 invert", ~32'h00000014);
        set_cfg(1'b1, 4'd3, 3'd4, 1'b0, 1'b1, 1'b1);
        check("R12 reverse and invert", ~32'h28000000);
        set_cfg(1'b1, 4'd3, 3'd4, 1'b0, 1'b0, 1'b0);
        check("R11 R12 stored value intact", 32'h00000014);

        // R13: unused mode codes
        for (int m = 5; m < 8; m++) begin
            set_cfg(1'b1, 4'd1, 3'(m), 1'b0, 1'b0, 1'b0);
            seed(32'h600D0000 + 32'(m));
            beat(4'd1, 32'hFFFFFFFF);
            check($sformatf("R13 mode %0d holds", m), 32'h600D0000 + 32'(m));
        end

        // R1: reset mid-run clears accumulator and disables unit
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset", 32'h0);
        beat(4'd0, 32'h12345678);
        check("R1 disabled after reset", 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule